// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital control core of a multichannel sampling converter. A host sends a write strobe, qualified by an active-low chip select, over a shared 8-bit bus. The strobe's leading edge freezes every channel's sample in one cycle. Its trailing edge loads one channel's settings into a per-channel configuration store and, unless told not to, launches a conversion sequence. The analog front end and the successive-approximation core are modelled by a digital sample bus. One result code per converted channel is written to a result RAM port. A ready flag stays low for the whole sequence.

Two kinds of operation are supported. In programmed mode, the bus word picks a channel and sets its polarity and its single-ended or paired input. It also sets inhibit and power-down flags, and it chooses whether the whole configured set or only the addressed channel is converted. Polarity and pairing settings are pipelined: they reach the conversions only after the launch that wrote them. In strapped mode, static pins choose eight single-ended or four paired channels and the polarity, and the bus contents are ignored.

Top module: `sampling_seq`

## Requirements
- R1: After synchronous reset, `ready` is 1, `res_we` is 0, no channel is enabled, power-down is off, and every stored polarity and pairing bit is 0.
- R2: A strobe counts only while both `cs_n` and `wr_n` are low. It is synchronised before edge detection. Strobes arriving while `ready` is 0 change neither the held samples nor the configuration.
- R3: The strobe's leading edge captures all channels of `samp_in` together, selected or not. Later changes of `samp_in` do not affect that conversion's results.
- R4: The trailing edge loads the bus word. Its bit fields are: bits 2:0 channel address, bit 3 power-down, bit 4 inhibit, bit 5 bipolar, bit 6 paired, bit 7 single-channel. With inhibit=1 the word is stored and no conversion starts.
- R5: The address and channel enable apply to the conversion the same write launches. The bipolar and paired bits written for a channel are used only from the following launch onward.
- R6: With bit 7 = 0, every enabled channel is converted in ascending index order. With bit 7 = 1, only the addressed channel is converted. Every programmed write enables its addressed channel.
- R7: Each converted channel takes exactly 18 cycles, and `res_we` pulses once in the last cycle of each slot. `ready` is low for exactly 18×N cycles and rises in the cycle after the final result write.
- R8: Paired inputs are (0,1), (2,3), (4,5) and (6,7). Writing paired=1 to channel c makes c the positive input and disables c's partner, so the most recent paired write in a pair sets the positive side.
- R9: A word with power-down=1 never starts a conversion, but it is still stored. A later word with power-down=0 and inhibit=0 starts normally, using the settings stored during power-down.
- R10: With `io_mode`=0, `strap_diff`=0 converts all eight channels single-ended and `strap_diff`=1 converts the pairs with even channels positive at addresses 0,2,4,6. `strap_bipolar` picks the polarity, and the bus and stored configuration are left untouched.
- R11: With positive input p and negative input n (8-bit unsigned samples), the result codes are: unipolar single-ended p; bipolar single-ended p−128 in two's complement; unipolar paired p−n, clamped at 0; bipolar paired floor((p−n)/2) in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select qualifying the strobe |
| wr_n | input | 1 | Active-low write strobe (asynchronous) |
| bus_in | input | 8 | Configuration word, sampled at strobe release |
| io_mode | input | 1 | 1 = programmed mode, 0 = strapped mode |
| strap_diff | input | 1 | Strapped mode: 1 = four paired channels |
| strap_bipolar | input | 1 | Strapped mode: 1 = bipolar coding |
| samp_in | input | NCH*8 | Digital stand-in for all channel inputs, channel i at bits 8i+7:8i |
| ready | output | 1 | High when idle, low while a sequence runs |
| res_we | output | 1 | Result RAM write enable |
| res_addr | output | $clog2(NCH) | Result RAM address (channel index) |
| res_data | output | 8 | Result code |

## Verification
The hardest state to reach from the ports is a conversion that runs on settings that are out of step with the latest write. This covers pipelined polarity and pairing, settings loaded during power-down, and strobes that land mid-sequence. The stimulus sets it up on purpose with back-to-back launches to one channel, an inhibited pair-conflict sequence, and a second strobe issued while `ready` is still low. A bench model holds both the pending and the applied settings, so random words also walk through these lag cases.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int SMP_W = 8;

    // Bus word layout (bit 7 down to bit 0)
    typedef struct packed {
        logic       single;   // 1: addressed channel only
        logic       paired;   // paired input for addressed channel
        logic       bipolar;  // bipolar coding for addressed channel
        logic       inhibit;  // store only, do not launch
        logic       pwr_down; // block conversions
        logic [2:0] addr;     // channel address
    } cfg_word_t;

    typedef enum logic {SQ_IDLE = 1'b0, SQ_RUN = 1'b1} seq_state_t;

    function automatic logic [SMP_W-1:0] code_of(
        input logic [SMP_W-1:0] pos,
        input logic [SMP_W-1:0] neg,
        input logic             bip,
        input logic             dif
    );
        logic [SMP_W:0] delta;
        delta = {1'b0, pos} - {1'b0, neg};
        if (!dif)
            code_of = bip ? (pos ^ {1'b1, {(SMP_W-1){1'b0}}}) : pos;
        else if (bip)
            code_of = delta[SMP_W:1];
        else
            code_of = delta[SMP_W] ? '0 : delta[SMP_W-1:0];
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_raw,
    output logic lead_p,
    output logic trail_p
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-1:0], strobe_raw};
    end

    assign lead_p  =  shreg[STAGES-1] & ~shreg[STAGES];
    assign trail_p = ~shreg[STAGES-1] &  shreg[STAGES];
endmodule

// File: rtl/cfg_store.sv
module cfg_store
    import seq_pkg::*;
#(
    parameter int NCH = 8,
    localparam int AW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  cfg_word_t       word,
    output logic [NCH-1:0]  en_q,
    output logic [NCH-1:0]  en_next,
    output logic [NCH-1:0]  sel,
    output logic [NCH-1:0]  pend_bip,
    output logic [NCH-1:0]  pend_diff,
    output logic            pd_q
);
    logic [AW-1:0]  addr;
    logic [NCH-1:0] mate;

    assign addr = word.addr[AW-1:0];

    always_comb begin
        sel        = '0;
        sel[addr]  = 1'b1;
        mate       = '0;
        mate[{addr[AW-1:1], ~addr[0]}] = 1'b1;
        en_next    = (en_q | sel) & ~(word.paired ? mate : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            pend_bip  <= '0;
            pend_diff <= '0;
            pd_q      <= 1'b0;
        end else if (wr_en) begin
            en_q            <= en_next;
            pend_bip[addr]  <= word.bipolar;
            pend_diff[addr] <= word.paired;
            pd_q            <= word.pwr_down;
        end
    end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import seq_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CYC_PER_CH = 18,
    localparam int AW = $clog2(NCH),
    localparam int CW = $clog2(CYC_PER_CH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic [NCH*SMP_W-1:0] samp_in,
    input  logic               start,
    input  logic [NCH-1:0]     mask_in,
    input  logic [NCH-1:0]     bip_in,
    input  logic [NCH-1:0]     diff_in,
    output logic               busy,
    output logic               res_we,
    output logic [AW-1:0]      res_addr,
    output logic [SMP_W-1:0]   res_data
);
    logic [SMP_W-1:0] held [NCH];
    seq_state_t       state;
    logic [NCH-1:0]   mask, bip_q, diff_q, rest;
    logic [CW-1:0]    cnt;
    logic [AW-1:0]    cur, mate;
    logic             slot_end;

    always_comb begin
        cur = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (mask[i]) cur = AW'(i);
    end

    assign mate     = {cur[AW-1:1], ~cur[0]};
    assign busy     = (state == SQ_RUN);
    assign slot_end = (cnt == CW'(CYC_PER_CH - 1));
    assign res_we   = busy && slot_end;
    assign res_addr = cur;
    assign res_data = code_of(held[cur], held[mate], bip_q[cur], diff_q[cur]);
    assign rest     = mask & ~(NCH'(1) << cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) held[i] <= '0;
        end else if (capture) begin
            for (int i = 0; i < NCH; i++) held[i] <= samp_in[i*SMP_W +: SMP_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            mask   <= '0;
            bip_q  <= '0;
            diff_q <= '0;
            cnt    <= '0;
        end else if (start) begin
            state  <= (|mask_in) ? SQ_RUN : SQ_IDLE;
            mask   <= mask_in;
            bip_q  <= bip_in;
            diff_q <= diff_in;
            cnt    <= '0;
        end else if (busy) begin
            if (slot_end) begin
                cnt  <= '0;
                mask <= rest;
                if (rest == '0) state <= SQ_IDLE;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sampling_seq.sv
module sampling_seq
    import seq_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CYC_PER_CH = 18,
    parameter int SYNC_STAGES = 2,
    localparam int AW = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 wr_n,
    input  logic [7:0]           bus_in,
    input  logic                 io_mode,
    input  logic                 strap_diff,
    input  logic                 strap_bipolar,
    input  logic [NCH*SMP_W-1:0] samp_in,
    output logic                 ready,
    output logic                 res_we,
    output logic [AW-1:0]        res_addr,
    output logic [SMP_W-1:0]     res_data
);
    logic           lead_p, trail_p, busy, cfg_wr, start;
    cfg_word_t      word;
    logic [NCH-1:0] en_q, en_next, sel, pend_bip, pend_diff;
    logic [NCH-1:0] even_mask, mask_in, bip_in, diff_in;
    logic           pd_q;

    assign word = cfg_word_t'(bus_in);

    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .strobe_raw(~cs_n & ~wr_n),
        .lead_p(lead_p), .trail_p(trail_p)
    );

    assign cfg_wr = trail_p & ~busy & io_mode;
    assign start  = trail_p & ~busy &
                    (io_mode ? (~word.inhibit & ~word.pwr_down) : 1'b1);

    cfg_store #(.NCH(NCH)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(cfg_wr), .word(word),
        .en_q(en_q), .en_next(en_next), .sel(sel),
        .pend_bip(pend_bip), .pend_diff(pend_diff), .pd_q(pd_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_even
        assign even_mask[g] = (g % 2 == 0);
    end

    always_comb begin
        if (io_mode) begin
            mask_in = word.single ? sel : en_next;
            bip_in  = pend_bip;
            diff_in = pend_diff;
        end else begin
            mask_in = strap_diff ? even_mask : '1;
            bip_in  = {NCH{strap_bipolar}};
            diff_in = {NCH{strap_diff}};
        end
    end

    conv_seq #(.NCH(NCH), .CYC_PER_CH(CYC_PER_CH)) u_conv (
        .clk(clk), .rst(rst), .capture(lead_p & ~busy), .samp_in(samp_in),
        .start(start), .mask_in(mask_in), .bip_in(bip_in), .diff_in(diff_in),
        .busy(busy), .res_we(res_we), .res_addr(res_addr), .res_data(res_data)
    );

    assign ready = ~busy;
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
    parameter int NCH = 8,
    parameter int CYC_PER_CH = 18,
    localparam int AW = $clog2(NCH),
    localparam int CW = $clog2(CYC_PER_CH)
) (
    input logic          clk,
    input logic          rst,
    input logic          ready,
    input logic          res_we,
    input logic [AW-1:0] res_addr,
    input logic          io_mode,
    input logic          strap_diff
);
    logic [CW-1:0] slot;
    logic          have_last;
    logic [AW-1:0] last_addr;

    always_ff @(posedge clk) begin
        if (rst || ready) begin
            slot      <= '0;
            have_last <= 1'b0;
            last_addr <= '0;
        end else begin
            slot <= (slot == CW'(CYC_PER_CH - 1)) ? '0 : slot + 1'b1;
            if (res_we) begin
                have_last <= 1'b1;
                last_addr <= res_addr;
            end
        end
    end

    // R7
    we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        res_we |-> !ready);
    // R7
    we_slot_end_chk: assert property (@(posedge clk) disable iff (rst)
        res_we |-> slot == CW'(CYC_PER_CH - 1));
    // R7
    ready_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(res_we));
    // R6
    ascending_order_chk: assert property (@(posedge clk) disable iff (rst)
        (res_we && have_last) |-> res_addr > last_addr);
    // R10
    strap_pair_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (res_we && !io_mode && strap_diff) |-> !res_addr[0]);
endmodule

bind sampling_seq seq_chk #(.NCH(NCH), .CYC_PER_CH(CYC_PER_CH)) u_seq_chk (
    .clk(clk), .rst(rst), .ready(ready), .res_we(res_we),
    .res_addr(res_addr), .io_mode(io_mode), .strap_diff(strap_diff)
);

// File: tb/tb_sampling_seq.sv
module tb_sampling_seq;
    localparam int NCH = 8;
    localparam int CYC = 18;

    logic             clk = 0, rst = 1, cs_n = 1, wr_n = 1;
    logic             io_mode = 1, strap_diff = 0, strap_bipolar = 0;
    logic [7:0]       bus_in = '0;
    logic [NCH*8-1:0] samp_in = '0;
    logic             ready, res_we;
    logic [2:0]       res_addr;
    logic [7:0]       res_data;

    always #2 clk = ~clk;

    sampling_seq #(.NCH(NCH), .CYC_PER_CH(CYC)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .bus_in(bus_in),
        .io_mode(io_mode), .strap_diff(strap_diff), .strap_bipolar(strap_bipolar),
        .samp_in(samp_in), .ready(ready), .res_we(res_we),
        .res_addr(res_addr), .res_data(res_data)
    );

    int  checks = 0, fails = 0;
    bit  done = 0;

    // model state
    logic [NCH-1:0] m_en = '0;
    logic           m_pb [NCH];
    logic           m_pdf [NCH];
    logic [7:0]     cur_s [NCH];
    int             exp_a [NCH];
    logic [7:0]     exp_d [NCH];
    int             exp_n;

    // recorder
    int         rec_n = 0, busy_cnt = 0;
    int         rec_a [16];
    logic [7:0] rec_d [16];

    always @(negedge clk) begin
        if (res_we) begin
            if (rec_n < 16) begin
                rec_a[rec_n] = int'(res_addr);
                rec_d[rec_n] = res_data;
            end
            rec_n++;
        end
        if (!ready) busy_cnt++;
    end

    function automatic logic [7:0] ref_code(logic [7:0] p, logic [7:0] n, logic b, logic d);
        int v;
        if (!d) v = b ? int'(p) - 128 : int'(p);
        else begin
            v = int'(p) - int'(n);
            if (b) v = v >>> 1;
            else if (v < 0) v = 0;
        end
        return v[7:0];
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic gen_samples();
        for (int i = 0; i < NCH; i++) cur_s[i] = 8'($urandom_range(0, 255));
    endtask

    task automatic arm();
        @(posedge clk);
        rec_n = 0;
        busy_cnt = 0;
    endtask

    task automatic pulse(logic [7:0] w, bit cs);
        @(negedge clk);
        for (int i = 0; i < NCH; i++) samp_in[i*8 +: 8] = cur_s[i];
        bus_in = w;
        cs_n = ~cs;
        @(negedge clk);
        wr_n = 0;
        repeat (4) @(negedge clk);
        wr_n = 1;
        repeat (5) @(negedge clk);
        cs_n = 1;
        bus_in = 8'($urandom);
        samp_in = {$urandom, $urandom};
    endtask

    task automatic build_exp(logic [NCH-1:0] mk, logic b [NCH], logic d [NCH]);
        exp_n = 0;
        for (int c = 0; c < NCH; c++) begin
            if (mk[c]) begin
                exp_a[exp_n] = c;
                exp_d[exp_n] = ref_code(cur_s[c], cur_s[c ^ 1], b[c], d[c]);
                exp_n++;
            end
        end
    endtask

    task automatic model_io(logic [7:0] w, output bit conv);
        int a;
        logic [NCH-1:0] sel, mate, en_n, mk;
        a    = int'(w[2:0]);
        sel  = NCH'(1) << a;
        mate = NCH'(1) << (a ^ 1);
        en_n = (m_en | sel) & ~(w[6] ? mate : '0);
        mk   = w[7] ? sel : en_n;
        conv = !w[4] && !w[3];
        if (conv) build_exp(mk, m_pb, m_pdf);
        m_en     = en_n;
        m_pb[a]  = w[5];
        m_pdf[a] = w[6];
    endtask

    task automatic finish_op(string req, bit conv);
        if (!conv) begin
            repeat (3) @(negedge clk);
            check(ready === 1'b1 && rec_n == 0, req, rec_n, 0);
        end else begin
            int t = 0;
            check(ready === 1'b0, req, int'(ready), 0);
            while (ready !== 1'b1 && t < 3000) begin
                @(negedge clk);
                t++;
            end
            check(rec_n == exp_n, req, rec_n, exp_n);
            for (int i = 0; i < exp_n && i < rec_n; i++) begin
                check(rec_a[i] == exp_a[i], req, rec_a[i], exp_a[i]);
                check(rec_d[i] == exp_d[i], req, int'(rec_d[i]), int'(exp_d[i]));
            end
            // R7 busy length
            check(busy_cnt == CYC * exp_n, "R7", busy_cnt, CYC * exp_n);
        end
    endtask

    task automatic op_io(logic [7:0] w, string req);
        bit conv;
        gen_samples();
        arm();
        model_io(w, conv);
        pulse(w, 1'b1);
        finish_op(req, conv);
    endtask

    task automatic op_strap(string req);
        logic b [NCH];
        logic d [NCH];
        for (int i = 0; i < NCH; i++) begin
            b[i] = strap_bipolar;
            d[i] = strap_diff;
        end
        gen_samples();
        arm();
        build_exp(strap_diff ? 8'h55 : 8'hFF, b, d);
        pulse(8'($urandom), 1'b1);
        finish_op(req, 1'b1);
    endtask

    // word: {single, paired, bipolar, inhibit, pwr_down, addr[2:0]}
    function automatic logic [7:0] mk_w(bit sg, bit pr, bit bp, bit ih, bit pd, int a);
        return {sg, pr, bp, ih, pd, 3'(a)};
    endfunction

    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_pb[i] = 0;
            m_pdf[i] = 0;
        end
        void'($urandom(32'h5eed));
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(ready === 1'b1, "R1", int'(ready), 1);
        check(res_we === 1'b0, "R1", int'(res_we), 0);

        // R10 strapped modes, bus ignored
        io_mode = 0;
        op_strap("R10 single-ended unipolar");
        strap_diff = 1; strap_bipolar = 1;
        op_strap("R10 R11 paired bipolar");
        strap_diff = 0;
        op_strap("R10 R11 single-ended bipolar");
        strap_diff = 1; strap_bipolar = 0;
        op_strap("R10 R11 paired unipolar");
        io_mode = 1;

        // R1/R6 empty store: only the addressed channel converts
        op_io(mk_w(0, 0, 0, 0, 0, 5), "R1 R6 empty store");
        // R4 inhibited loads
        op_io(mk_w(1, 0, 1, 1, 0, 0), "R4 inhibit");
        op_io(mk_w(1, 0, 0, 1, 0, 2), "R4 inhibit");
        // R6 ascending all-channel, ch0 bipolar from earlier load
        op_io(mk_w(0, 0, 0, 0, 0, 2), "R6 R11 ascending");
        // R5 pipelined polarity
        op_io(mk_w(1, 0, 1, 0, 0, 2), "R5 first launch old polarity");
        op_io(mk_w(1, 0, 1, 0, 0, 2), "R5 second launch new polarity");
        // R8 pair conflict
        op_io(mk_w(1, 1, 0, 1, 0, 4), "R8 load");
        op_io(mk_w(1, 1, 1, 1, 0, 5), "R8 load");
        op_io(mk_w(0, 1, 1, 0, 0, 5), "R8 R11 conflict");
        // R9 power-down
        op_io(mk_w(1, 0, 0, 0, 1, 1), "R9 blocked");
        op_io(mk_w(1, 0, 1, 1, 1, 6), "R9 load while down");
        op_io(mk_w(1, 0, 1, 0, 0, 6), "R9 resume");
        // R2 chip select high: not seen
        gen_samples();
        arm();
        pulse(mk_w(1, 0, 0, 0, 0, 6), 1'b0);
        finish_op("R2 cs high", 1'b0);
        op_io(mk_w(1, 0, 0, 0, 0, 6), "R2 cs-high word not loaded");
        // R2/R3 strobe during a run is ignored
        begin
            bit conv;
            logic [7:0] wa;
            wa = mk_w(0, 0, 0, 0, 0, 0);
            gen_samples();
            arm();
            model_io(wa, conv);
            pulse(wa, 1'b1);
            gen_samples();
            pulse(mk_w(1, 1, 1, 0, 0, 3), 1'b1);
            finish_op("R2 R3 strobe while busy", conv);
        end
        // random
        for (int k = 0; k < 40; k++) begin
            logic [7:0] w;
            w = 8'($urandom);
            if (w[3] && $urandom_range(0, 3) != 0) w[3] = 1'b0;
            op_io(w, "R5 R6 R8 R9 R11 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule